// File: doc/BRIEF.md
# Banked Memory Controller with Periodic Interrupt

This block sits between an 8-bit CPU with a 16-bit address bus and its program ROM and working RAM. The upper half of the CPU address space always shows the last 32 KB of program ROM, so the reset vector at 0xFFFE/0xFFFF is fetched from the final two ROM bytes. A 16 KB window at 0x4000–0x7FFF shows one ROM bank, chosen by a bank register at 0x3FFC. The bottom 8 KB holds on-chip RAM. The remaining I/O space reads as zero.

The same block provides the timer interrupt the firmware waits for in its idle loop. It counts bus clock enables. Every `TICK_DIV` enables it raises `irq`. The request stays high until the CPU writes to the acknowledge address 0x3FF7. With a 2 MHz enable and the default divider, the rate is 1 kHz.

All state changes on the rising edge of one clock, and only when `bus_ce` is high. Address decode and read-data selection are combinational from the current bus cycle.

Top module: `bank_memctl`

## Requirements
- R1: After reset the bank register reads 0 and `irq` is low.
- R2: For CPU addresses 0x8000–0xFFFF, `rom_sel` is 1 and `rom_addr` is all ones in its bits above 14, with `cpu_addr[14:0]` below them. So 0xFFFE and 0xFFFF map to the last two ROM bytes.
- R3: For CPU addresses 0x4000–0x7FFF, `rom_sel` is 1 and `rom_addr` equals {bank, `cpu_addr[13:0]`}.
- R4: A write to 0x3FFC with `bus_ce` high loads the low `BANK_W` bits of `cpu_wdata` into the bank register and drops the higher bits. A read of 0x3FFC returns the bank, zero-extended.
- R5: Addresses 0x0000–0x1FFF select on-chip RAM of 2^`RAM_AW` bytes, mirrored across that range. A read returns exactly the byte last written at that location, including 0x55 and 0xAA.
- R6: In both ROM regions, `cpu_rdata` equals `rom_rdata`. Reads in 0x2000–0x3FFF other than 0x3FFC return 0x00.
- R7: `ram_sel` is 1 exactly in the RAM range. `rom_sel` is 0 outside the two ROM regions. The two selects are never both 1.
- R8: `irq` goes high on the `bus_ce` edge that completes every `TICK_DIV`-th enable after reset, counted without gaps.
- R9: Once high, `irq` stays high until a write to 0x3FF7 with `bus_ce` high clears it. If a tick and an acknowledge fall on the same enable, the tick wins and `irq` stays high.
- R10: When `bus_ce` is low, writes are ignored. The timer, `irq`, the bank register and RAM keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single synchronous clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ce | input | 1 | Bus clock enable; one bus cycle per high cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | 1 = write cycle, 0 = read cycle |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | BANK_W+14 | External program ROM byte address |
| rom_sel | output | 1 | ROM chip select |
| ram_sel | output | 1 | On-chip RAM select |
| rom_rdata | input | 8 | Data from the external ROM |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The properties assume the following about the inputs:
- `TICK_DIV` is at least 2 and `BANK_W` is at least 2.
- `bus_ce` and `cpu_we` are known whenever reset is released.
- The timer's enable count starts from the reset release.

The stimulus drives every bus input on the falling clock edge and holds it across exactly one rising edge. It asserts `bus_ce` only for the cycles it counts, so the expected interrupt edge can be found by counting enables in the bench. Some write cycles deliberately leave `bus_ce` low to show they are ignored.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    typedef enum logic [1:0] {
        RGN_RAM = 2'd0,
        RGN_IO  = 2'd1,
        RGN_WIN = 2'd2,
        RGN_FIX = 2'd3
    } region_e;

    localparam logic [15:0] BANK_REG_ADDR = 16'h3FFC;
    localparam logic [15:0] IRQ_ACK_ADDR  = 16'h3FF7;

endpackage

// File: rtl/bmc_decode.sv
module bmc_decode
    import bmc_pkg::*;
#(
    parameter int BANK_W = 6
) (
    input  logic [15:0]          addr,
    input  logic [BANK_W-1:0]    bank,
    output region_e              region,
    output logic                 bank_hit,
    output logic                 ack_hit,
    output logic [BANK_W+13:0]   rom_addr
);
    localparam int ROM_AW = BANK_W + 14;

    always_comb begin
        if (addr[15])
            region = RGN_FIX;
        else if (addr[14])
            region = RGN_WIN;
        else if (!addr[13])
            region = RGN_RAM;
        else
            region = RGN_IO;

        bank_hit = (addr == BANK_REG_ADDR);
        ack_hit  = (addr == IRQ_ACK_ADDR);

        unique case (region)
            RGN_FIX: rom_addr = {{(BANK_W - 1){1'b1}}, addr[14:0]};
            RGN_WIN: rom_addr = {bank, addr[13:0]};
            default: rom_addr = '0;
        endcase
    end

    initial begin
        if (ROM_AW < 16)
            $error("bmc_decode: BANK_W must be at least 2");
    end

endmodule

// File: rtl/bmc_bank_reg.sv
module bmc_bank_reg #(
    parameter int BANK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce,
    input  logic              we,
    input  logic              hit,
    input  logic [7:0]        wdata,
    output logic [BANK_W-1:0] bank
);
    typedef struct packed {
        logic [BANK_W-1:0] bank;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_ce && we && hit)
            st_d.bank = wdata[BANK_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign bank = st_q.bank;

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ce && we && hit) |=> (st_q.bank == $past(wdata[BANK_W-1:0]))); // R4
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ce && we && hit) |=> $stable(st_q.bank)); // R10

endmodule

// File: rtl/bmc_irq_timer.sv
module bmc_irq_timer #(
    parameter int TICK_DIV = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_ce,
    input  logic ack,
    output logic irq
);
    localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             irq;
    } tick_state_t;

    tick_state_t st_d, st_q;
    logic        wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.count == CNT_LAST);
        if (bus_ce) begin
            st_d.count = wrap ? '0 : st_q.count + 1'b1;
            if (wrap)
                st_d.irq = 1'b1;
            else if (ack)
                st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign irq = st_q.irq;

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_LAST); // R8
    AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ce && st_q.count == CNT_LAST) |=> st_q.irq); // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !(bus_ce && ack)) |=> st_q.irq); // R9
    AST_IRQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.irq && !(bus_ce && st_q.count == CNT_LAST)) |=> !st_q.irq); // R8
    AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ce |=> ($stable(st_q.count) && $stable(st_q.irq))); // R10

endmodule

// File: rtl/bmc_ram.sv
module bmc_ram #(
    parameter int RAM_AW = 11
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [RAM_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/bank_memctl.sv
module bank_memctl
    import bmc_pkg::*;
#(
    parameter int BANK_W   = 6,
    parameter int RAM_AW   = 11,
    parameter int TICK_DIV = 2000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_ce,
    input  logic [15:0]         cpu_addr,
    input  logic [7:0]          cpu_wdata,
    input  logic                cpu_we,
    output logic [7:0]          cpu_rdata,
    output logic [BANK_W+13:0]  rom_addr,
    output logic                rom_sel,
    output logic                ram_sel,
    input  logic [7:0]          rom_rdata,
    output logic                irq
);
    region_e           region;
    logic              bank_hit;
    logic              ack_hit;
    logic [BANK_W-1:0] bank;
    logic [7:0]        ram_rdata;
    logic              ram_wr;

    bmc_decode #(.BANK_W(BANK_W)) i_decode (
        .addr     (cpu_addr),
        .bank     (bank),
        .region   (region),
        .bank_hit (bank_hit),
        .ack_hit  (ack_hit),
        .rom_addr (rom_addr)
    );

    bmc_bank_reg #(.BANK_W(BANK_W)) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_ce (bus_ce),
        .we     (cpu_we),
        .hit    (bank_hit),
        .wdata  (cpu_wdata),
        .bank   (bank)
    );

    bmc_irq_timer #(.TICK_DIV(TICK_DIV)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_ce (bus_ce),
        .ack    (cpu_we && ack_hit),
        .irq    (irq)
    );

    assign ram_wr = bus_ce && cpu_we && (region == RGN_RAM);

    bmc_ram #(.RAM_AW(RAM_AW)) i_ram (
        .clk   (clk),
        .wr_en (ram_wr),
        .addr  (cpu_addr[RAM_AW-1:0]),
        .wdata (cpu_wdata),
        .rdata (ram_rdata)
    );

    always_comb begin
        rom_sel   = (region == RGN_FIX) || (region == RGN_WIN);
        ram_sel   = (region == RGN_RAM);
        cpu_rdata = 8'h00;
        unique case (region)
            RGN_FIX, RGN_WIN: cpu_rdata = rom_rdata;
            RGN_RAM:          cpu_rdata = ram_rdata;
            default:          cpu_rdata = bank_hit ? 8'(bank) : 8'h00;
        endcase
    end

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_sel, ram_sel})); // R7
    AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[15] |-> (rom_sel && (&rom_addr[BANK_W+13:15]))); // R2
    AST_WINDOW_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b01) |-> (rom_sel && rom_addr[BANK_W+13:14] == bank)); // R3

endmodule

// File: tb/test_bank_memctl.sv
module test_bank_memctl;
    localparam int BW  = 3;
    localparam int RAW = 6;
    localparam int DIV = 10;
    localparam int RW  = BW + 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_ce = 1'b0;
    logic [15:0]   cpu_addr = 16'h8000;
    logic [7:0]    cpu_wdata = 8'h00;
    logic          cpu_we = 1'b0;
    logic [7:0]    cpu_rdata;
    logic [RW-1:0] rom_addr;
    logic          rom_sel;
    logic          ram_sel;
    logic [7:0]    rom_rdata;
    logic          irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign rom_rdata = rom_addr[7:0] + 8'h3C;

    bank_memctl #(.BANK_W(BW), .RAM_AW(RAW), .TICK_DIV(DIV)) i_bank_memctl (
        .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_rdata(cpu_rdata),
        .rom_addr(rom_addr), .rom_sel(rom_sel), .ram_sel(ram_sel),
        .rom_rdata(rom_rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic ce, input logic we, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_ce = ce; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        bus_ce = 1'b0; cpu_we = 1'b0;
        #1;
    endtask

    task automatic look(input logic [15:0] a);
        @(negedge clk);
        bus_ce = 1'b0; cpu_we = 1'b0; cpu_addr = a;
        #1;
    endtask

    task automatic ce_pulses(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 16'h8000, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        look(16'h3FFC);
        chk("R1 bank after reset", cpu_rdata, 0);
        chk("R1 irq after reset", irq, 0);

        look(16'hFFFE);
        chk("R2 vector low", rom_addr, (1 << RW) - 2);
        chk("R6 vector data", cpu_rdata, 8'(((1 << RW) - 2) + 8'h3C));
        look(16'hFFFF);
        chk("R2 vector high", rom_addr, (1 << RW) - 1);
        for (int a = 16'h8000; a <= 16'hFFFF; a += 16'h0FF3) begin
            look(16'(a));
            chk("R2 fixed map", rom_addr, ((1 << RW) - 32768) + (a & 16'h7FFF));
            chk("R7 fixed sel", {rom_sel, ram_sel}, 2'b10);
        end

        for (int b = 0; b < (1 << BW); b++) begin
            cyc(1'b1, 1'b1, 16'h3FFC, 8'(b | 8'hF8));
            look(16'h3FFC);
            chk("R4 bank readback", cpu_rdata, b);
            for (int o = 0; o < 16384; o += 4093) begin
                look(16'(16'h4000 + o));
                chk("R3 window map", rom_addr, (b << 14) + o);
                chk("R6 window data", cpu_rdata, 8'(((b << 14) + o) + 8'h3C));
                chk("R7 window sel", {rom_sel, ram_sel}, 2'b10);
            end
        end
        cyc(1'b0, 1'b1, 16'h3FFC, 8'h02);
        look(16'h3FFC);
        chk("R10 bank write without ce", cpu_rdata, 7);

        for (int pat = 0; pat < 2; pat++) begin
            for (int a = 0; a < (1 << RAW); a++)
                cyc(1'b1, 1'b1, 16'(a), pat ? 8'hAA : 8'h55);
            for (int a = 0; a < (1 << RAW); a++) begin
                look(16'(a));
                chk("R5 ram pattern", cpu_rdata, pat ? 8'hAA : 8'h55);
                chk("R7 ram sel", {rom_sel, ram_sel}, 2'b01);
            end
        end
        cyc(1'b1, 1'b1, 16'h1FC5, 8'h3D);
        look(16'h0005);
        chk("R5 ram mirror", cpu_rdata, 8'h3D);
        cyc(1'b0, 1'b1, 16'h0005, 8'h11);
        look(16'h0005);
        chk("R10 ram write without ce", cpu_rdata, 8'h3D);
        look(16'h2000);
        chk("R6 io zero", cpu_rdata, 0);
        chk("R7 io sel", {rom_sel, ram_sel}, 2'b00);
        look(16'h3FF7);
        chk("R6 ack addr reads zero", cpu_rdata, 0);

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ce_pulses(DIV - 1);
        chk("R8 no irq before period", irq, 0);
        ce_pulses(1);
        chk("R8 irq at period", irq, 1);
        repeat (4) look(16'h8000);
        chk("R10 irq held without ce", irq, 1);
        ce_pulses(5);
        chk("R9 irq held", irq, 1);
        cyc(1'b0, 1'b1, 16'h3FF7, 8'h00);
        chk("R10 ack without ce", irq, 1);
        cyc(1'b1, 1'b1, 16'h3FF7, 8'h00);
        chk("R9 ack clears", irq, 0);
        ce_pulses(3);
        chk("R8 no early irq", irq, 0);
        ce_pulses(1);
        chk("R8 second period", irq, 1);
        ce_pulses(DIV - 1);
        cyc(1'b1, 1'b1, 16'h3FF7, 8'h00);
        chk("R9 tick beats ack", irq, 1);
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 150000 && !done; t++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule